// File: doc/BRIEF.md
# Dice Game Point Controller

This block referees the two-dice point game. A dice counter elsewhere on the chip free-runs while it is enabled and presents the sum of two dice. The controller enables that counter while the player holds the roll button. When the button is let go it judges the sum that the counter shows in that cycle. The first roll and every later roll follow different rules. A first roll that decides nothing has its sum kept as the point. After that the game goes on until the point comes up again or a seven does.

The block holds the game state machine, a small decoder that classifies the incoming sum, and the point register with its equality comparator. The roll button is assumed to be already debounced and synchronized to the clock. An active-low asynchronous reset starts a new game. The win and lose outputs stay high until that reset arrives.

Top module: `dice_point_ctrl`

## Requirements
- R1: On the first roll, a release with a sum of 7 or 11 drives `win` high from the next clock edge on.
- R2: On the first roll, a release with a sum of 2, 3 or 12 drives `lose` high from the next clock edge on.
- R3: On the first roll, a release with any other sum raises `store_pt` during the release cycle, combinationally. No outcome follows, and the game then waits for a new button press.
- R4: The point is the sum taken at the first `store_pt` and never changes. On a later roll, a release with a sum equal to the point drives `win` high from the next edge on. `store_pt` is never raised on a later roll.
- R5: On a later roll, a release with a sum of 7 drives `lose` high from the next edge on.
- R6: On a later roll, a release with any other sum gives no outcome. The game waits, and only a new press starts another roll.
- R7: `roll_en` equals `roll_btn` while the game is in a roll state, meaning after the press has been registered. It is 0 in the start, waiting, win and lose states and in every release cycle.
- R8: Once `win` or `lose` is high it stays high and the other stays low until reset. Further presses neither enable the counter nor change the outcome.
- R9: Asserting `rst_n` low clears `win`, `lose`, `roll_en` and `store_pt` at once, without waiting for a clock edge, and the next game starts from its first roll.
- R10: Only the sum present in the release cycle is judged. Sums shown while the button is held have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, starts a new game |
| roll_btn | input | 1 | Synchronized, debounced roll button, 1 while pressed |
| dice_sum | input | SUM_W | Sum of the two dice from the dice counter (2 to 12) |
| roll_en | output | 1 | Dice counter enable |
| store_pt | output | 1 | Strobe that loads `dice_sum` into the point register at the next edge |
| win | output | 1 | Game won, held until reset |
| lose | output | 1 | Game lost, held until reset |

## Verification
`store_pt` and the release-cycle value of `roll_en` are Mealy outputs. The bench reads them 1 ns after it drives the release, inside the same cycle. `roll_en` becomes 1 one edge after the press, so the hold checks begin at the first falling edge after the press has been registered. `win` and `lose` come from the state register, one edge after the release, so they are checked at the following falling edge and then for idle cycles after it. The reset check reads the outputs 1 ns after `rst_n` falls, before any rising edge.

// File: rtl/dice_game_pkg.sv
package dice_game_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_FIRST = 3'd1,
        ST_WAIT  = 3'd2,
        ST_LATER = 3'd3,
        ST_WIN   = 3'd4,
        ST_LOSE  = 3'd5
    } game_state_e;

    typedef struct packed {
        game_state_e state;
    } game_regs_t;

endpackage

// File: rtl/dice_sum_class.sv
module dice_sum_class #(
    parameter int unsigned SUM_W    = 4,
    parameter int unsigned SEVEN    = 7,
    parameter int unsigned ELEVEN   = 11,
    parameter int unsigned CRAPS_LO = 2,
    parameter int unsigned CRAPS_MI = 3,
    parameter int unsigned CRAPS_HI = 12
) (
    input  logic [SUM_W-1:0] dice_sum,
    output logic             is_seven,
    output logic             is_natural,
    output logic             is_craps
);
    localparam logic [SUM_W-1:0] K_SEVEN  = SUM_W'(SEVEN);
    localparam logic [SUM_W-1:0] K_ELEVEN = SUM_W'(ELEVEN);
    localparam logic [SUM_W-1:0] K_CLO    = SUM_W'(CRAPS_LO);
    localparam logic [SUM_W-1:0] K_CMI    = SUM_W'(CRAPS_MI);
    localparam logic [SUM_W-1:0] K_CHI    = SUM_W'(CRAPS_HI);

    always_comb begin
        is_seven   = (dice_sum == K_SEVEN);
        is_natural = is_seven || (dice_sum == K_ELEVEN);
        is_craps   = (dice_sum == K_CLO) || (dice_sum == K_CMI) || (dice_sum == K_CHI);
    end
endmodule

// File: rtl/dice_point_store.sv
module dice_point_store #(
    parameter int unsigned SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SUM_W-1:0] dice_sum,
    output logic [SUM_W-1:0] point_q,
    output logic             match
);
    logic [SUM_W-1:0] point_d;

    always_comb begin
        point_d = point_q;
        if (load) begin
            point_d = dice_sum;
        end
        match = (dice_sum == point_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            point_q <= '0;
        end else begin
            point_q <= point_d;
        end
    end
endmodule

// File: rtl/dice_game_fsm.sv
module dice_game_fsm
    import dice_game_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic roll_btn,
    input  logic is_seven,
    input  logic is_natural,
    input  logic is_craps,
    input  logic matches_point,
    output logic roll_en,
    output logic store_pt,
    output logic win,
    output logic lose
);
    game_regs_t regs_d;
    game_regs_t regs_q;

    always_comb begin
        regs_d   = regs_q;
        roll_en  = 1'b0;
        store_pt = 1'b0;
        case (regs_q.state)
            ST_START: begin
                if (roll_btn) begin
                    regs_d.state = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (roll_btn) begin
                    roll_en = 1'b1;
                end else if (is_natural) begin
                    regs_d.state = ST_WIN;
                end else if (is_craps) begin
                    regs_d.state = ST_LOSE;
                end else begin
                    store_pt     = 1'b1;
                    regs_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (roll_btn) begin
                    regs_d.state = ST_LATER;
                end
            end
            ST_LATER: begin
                if (roll_btn) begin
                    roll_en = 1'b1;
                end else if (matches_point) begin
                    regs_d.state = ST_WIN;
                end else if (is_seven) begin
                    regs_d.state = ST_LOSE;
                end else begin
                    regs_d.state = ST_WAIT;
                end
            end
            ST_WIN, ST_LOSE: begin
                regs_d = regs_q;
            end
            default: begin
                regs_d.state = ST_START;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_START};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign win  = (regs_q.state == ST_WIN);
    assign lose = (regs_q.state == ST_LOSE);
endmodule

// File: rtl/dice_point_ctrl.sv
module dice_point_ctrl #(
    parameter int unsigned SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roll_btn,
    input  logic [SUM_W-1:0] dice_sum,
    output logic             roll_en,
    output logic             store_pt,
    output logic             win,
    output logic             lose
);
    logic             is_seven;
    logic             is_natural;
    logic             is_craps;
    logic             matches_point;
    logic [SUM_W-1:0] point_q;

    dice_sum_class #(.SUM_W(SUM_W)) u_class (
        .dice_sum   (dice_sum),
        .is_seven   (is_seven),
        .is_natural (is_natural),
        .is_craps   (is_craps)
    );

    dice_point_store #(.SUM_W(SUM_W)) u_point (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (store_pt),
        .dice_sum (dice_sum),
        .point_q  (point_q),
        .match    (matches_point)
    );

    dice_game_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .roll_btn      (roll_btn),
        .is_seven      (is_seven),
        .is_natural    (is_natural),
        .is_craps      (is_craps),
        .matches_point (matches_point),
        .roll_en       (roll_en),
        .store_pt      (store_pt),
        .win           (win),
        .lose          (lose)
    );
endmodule

// File: rtl/dice_point_ctrl_chk.sv
module dice_point_ctrl_chk #(
    parameter int unsigned SUM_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             roll_btn,
    input logic             roll_en,
    input logic             store_pt,
    input logic             win,
    input logic             lose,
    input logic [SUM_W-1:0] point_q
);
    // R7
    en_needs_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll_en |-> roll_btn);

    // R8
    win_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> (win && !lose));

    // R8
    lose_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lose |=> (lose && !win));

    // R3
    store_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pt |-> (!roll_btn && !win && !lose));

    // R3
    store_no_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pt |=> (!win && !lose && !store_pt));

    // R4
    point_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_pt |=> $stable(point_q));

    // R1
    win_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win) |-> !$past(roll_btn));

    // R2
    lose_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lose) |-> !$past(roll_btn));
endmodule

bind dice_point_ctrl dice_point_ctrl_chk #(.SUM_W(SUM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .roll_btn (roll_btn),
    .roll_en  (roll_en),
    .store_pt (store_pt),
    .win      (win),
    .lose     (lose),
    .point_q  (point_q)
);

// File: tb/dice_point_ctrl_bench.sv
`timescale 1ns/1ps
module dice_point_ctrl_bench;
    localparam int SUM_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             roll_btn = 1'b0;
    logic [SUM_W-1:0] dice_sum = '0;
    logic             roll_en;
    logic             store_pt;
    logic             win;
    logic             lose;

    int n_tests = 0;
    int n_fail  = 0;
    int m_phase = 0;   // 0 first roll, 1 later roll, 2 won, 3 lost
    int m_point = 0;

    always #2 clk = ~clk;

    dice_point_ctrl #(.SUM_W(SUM_W)) u_dice_point_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll_btn (roll_btn),
        .dice_sum (dice_sum),
        .roll_en  (roll_en),
        .store_pt (store_pt),
        .win      (win),
        .lose     (lose)
    );

    task automatic check(string tag, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic int first_result(int s);
        if (s == 7 || s == 11) return 1;
        if (s == 2 || s == 3 || s == 12) return 2;
        return 0;
    endfunction

    function automatic int two_dice();
        return int'($urandom_range(1, 6)) + int'($urandom_range(1, 6));
    endfunction

    function automatic string outcome_tag(int old_phase, int new_phase);
        if (old_phase >= 2) return "R8 outcome held";
        if (old_phase == 0) begin
            if (new_phase == 2) return "R1 first-roll win";
            if (new_phase == 3) return "R2 first-roll loss";
            return "R3 no outcome after point";
        end
        if (new_phase == 2) return "R4 point repeated";
        if (new_phase == 3) return "R5 later seven";
        return "R6 no outcome";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        roll_btn = 1'b0;
        #1;
        check("R9 win cleared", int'(win), 0);
        check("R9 lose cleared", int'(lose), 0);
        check("R9 roll_en cleared", int'(roll_en), 0);
        check("R9 store_pt cleared", int'(store_pt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_phase = 0;
        m_point = 0;
    endtask

    task automatic roll(int s, int hold);
        int old_phase;
        int r;
        int exp_store;
        @(negedge clk);
        roll_btn = 1'b1;
        dice_sum = SUM_W'(two_dice());
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(m_phase >= 2 ? "R8 counter stays off" : "R7 roll_en while held",
                  int'(roll_en), (m_phase < 2) ? 1 : 0);
            dice_sum = SUM_W'(two_dice());   // R10 noise while held
        end
        @(negedge clk);
        roll_btn = 1'b0;
        dice_sum = SUM_W'(s);
        #1;
        old_phase = m_phase;
        r = first_result(s);
        exp_store = (old_phase == 0 && r == 0) ? 1 : 0;
        check("R3 store_pt in release cycle", int'(store_pt), exp_store);
        check("R7 roll_en off at release", int'(roll_en), 0);
        if (old_phase == 0) begin
            if (r == 1) m_phase = 2;
            else if (r == 2) m_phase = 3;
            else begin
                m_phase = 1;
                m_point = s;
            end
        end else if (old_phase == 1) begin
            if (s == m_point) m_phase = 2;
            else if (s == 7) m_phase = 3;
        end
        @(negedge clk);
        dice_sum = SUM_W'(two_dice());
        check(outcome_tag(old_phase, m_phase), int'(win), (m_phase == 2) ? 1 : 0);
        check(outcome_tag(old_phase, m_phase), int'(lose), (m_phase == 3) ? 1 : 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(m_phase >= 2 ? "R8 win held" : "R6 idle no win", int'(win), (m_phase == 2) ? 1 : 0);
            check(m_phase >= 2 ? "R8 lose held" : "R6 idle no lose", int'(lose), (m_phase == 3) ? 1 : 0);
            check("R7 roll_en idle", int'(roll_en), 0);
            check("R4 no store while idle", int'(store_pt), 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240406));
        @(negedge clk);
        #1;
        check("R9 win in reset", int'(win), 0);
        check("R9 lose in reset", int'(lose), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 directed
        roll(7, 3);
        roll(4, 2);            // R8 pressing after win
        do_reset();
        roll(11, 1);
        do_reset();
        // R2 directed
        roll(2, 2);
        roll(7, 2);            // R8 a seven after loss changes nothing
        do_reset();
        roll(3, 1);
        do_reset();
        roll(12, 4);
        do_reset();
        // R3 R4 R6 point kept through later rolls, 2/3/12/11 ignored later
        roll(4, 2);
        roll(9, 1);
        roll(12, 3);
        roll(11, 2);
        roll(2, 1);
        roll(4, 2);
        do_reset();
        // R5 later seven
        roll(10, 2);
        roll(6, 1);
        roll(7, 5);
        roll(10, 1);           // R8 former point after loss
        do_reset();
        // R9 reset in mid game then fresh first roll
        roll(6, 2);
        do_reset();
        roll(6, 2);            // stored again as first roll
        roll(6, 1);
        do_reset();

        // random games
        for (int g = 0; g < 40; g++) begin
            for (int k = 0; k < 30 && m_phase < 2; k++) begin
                roll(two_dice(), int'($urandom_range(1, 4)));
            end
            do_reset();
        end
        finish_run();
    end
endmodule